// File: doc/BRIEF.md
# Programmable Parallel Port Controller

A bus-attached peripheral with three 8-bit parallel ports (A, B, C) and a write-only control register. A host reaches it through an 8-bit data bus using an active-low chip select, active-low read and write strobes and a 2-bit address. Each port pin has a separate data-out and output-enable signal, so the pad drivers sit outside the block. Both host strobes are sampled on the rising clock edge. A write takes effect at the first edge where both chip select and write are low.

A control write with bit 7 set is a mode word. It sets the direction of port A, port B and each half of port C. It also chooses basic or strobed operation for port B and clears every output latch. A control write with bit 7 clear sets or clears a single port C line and leaves the mode unchanged.

In strobed mode, port B borrows the three low lines of port C as handshake lines. Line 2 is the strobe or acknowledge input. Line 1 is the buffer flag. Line 0 is the interrupt request. Input pins are captured into a latch on every clock, and reads return that latch.

Top module: `pport_ctrl`

## Requirements
- R1: After reset, every output enable is 0, every output latch is 0, and a port C read returns the pins as captured.
- R2: Address 0 reads port A, 1 reads port B, 2 reads port C, 3 reads 0xFF. rdata is 0x00 whenever chip select or read is high.
- R3: In a mode word (bit 7 = 1), a 1 means input and a 0 means output. Bit 4 sets port A, bit 1 sets port B, bit 3 sets port C lines 7..4, and bit 0 sets line 3. Bit 0 also sets lines 2..0 when bit 2 is 0. An output group has all its enables at 1, an input group all at 0.
- R4: A mode word clears the port A, port B and port C output latches at the write edge.
- R5: A data write to port A, B or C is held on that port's outputs after the write ends. A read of an output port or line returns the latched value.
- R6: A read of an input port returns the pins as captured at the previous rising edge.
- R7: A control write with bit 7 = 0 writes bit 0 into the port C line given by bits 3..1. No output enable changes.
- R8: The two port C halves follow their own mode bits. Reading port C returns latch bits for output lines and pin bits for input lines.
- R9: With mode bit 2 = 1 and bit 1 = 1 (strobed input), the enables of lines 2..0 are 0,1,1. A falling edge on pin C2 captures the port B pins two edges after the low level is applied. At that edge, line C1 (buffer full) goes to 1 and line C0 (interrupt) takes the interrupt-enable value. A port B read then returns the captured byte.
- R10: In strobed input, a port B read clears both C1 and C0 at its edge.
- R11: In strobed mode, a set/reset command on line 2 writes the interrupt enable. Commands on lines 0 and 1 have no effect. A mode word clears the enable.
- R12: With mode bits 2 = 1 and 1 = 0 (strobed output), a mode word drives C1 to 1. A port B write drives C1 to 0 and C0 to 0. A falling edge on pin C2 drives C1 to 1 and C0 to the interrupt-enable value.
- R13: A mode word whose bits 6..5 are nonzero forces port A to input, whatever bit 4 says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A data out |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B data out |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C data out |
| pc_oe | output | 8 | Port C output enables |

## Verification
Writes, mode words and set/reset commands change the outputs at the write edge. The bench applies each strobe between falling edges and checks at the next falling edge. Read data is combinational from the latches, so it is sampled one time unit after the read is applied. A pin change reaches a read only after one rising edge, and the check of R6 sits on both sides of that edge. A handshake strobe acts two rising edges after its low level is applied, because the pin latch and the edge detector each add one register. The bench checks the flags at the falling edge after that second rising edge.

// File: rtl/pport_ctrl.sv
module pport_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  logic       a_in, cu_in, cl_in, b_in, b_strb;
  logic [7:0] a_lat, b_lat, c_lat;
  logic [7:0] a_q, b_q, c_q, b_cap;
  logic       stb_d, ibf, obf_n, intr, inte;
  logic [7:0] c_drv;

  logic wr_en, rd_en, mode_wr, bit_wr, hs_in, hs_out, hs_edge, hs_bit;
  logic [2:0] bsel;

  assign wr_en   = !cs_n && !wr_n;
  assign rd_en   = !cs_n && !rd_n;
  assign mode_wr = wr_en && addr == 2'd3 && wdata[7];
  assign bit_wr  = wr_en && addr == 2'd3 && !wdata[7];
  assign bsel    = wdata[3:1];
  assign hs_in   = b_strb && b_in;
  assign hs_out  = b_strb && !b_in;
  assign hs_edge = stb_d && !c_q[2];
  assign hs_bit  = b_strb && bsel < 3'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      stb_d <= 1'b0;
    end else begin
      a_q   <= pa_in;
      b_q   <= pb_in;
      c_q   <= pc_in;
      stb_d <= c_q[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_in   <= 1'b1;
      cu_in  <= 1'b1;
      cl_in  <= 1'b1;
      b_in   <= 1'b1;
      b_strb <= 1'b0;
      a_lat  <= '0;
      b_lat  <= '0;
      c_lat  <= '0;
      b_cap  <= '0;
      ibf    <= 1'b0;
      obf_n  <= 1'b1;
      intr   <= 1'b0;
      inte   <= 1'b0;
    end else if (mode_wr) begin
      a_in   <= wdata[4] | (|wdata[6:5]);
      cu_in  <= wdata[3];
      b_strb <= wdata[2];
      b_in   <= wdata[1];
      cl_in  <= wdata[0];
      a_lat  <= '0;
      b_lat  <= '0;
      c_lat  <= '0;
      ibf    <= 1'b0;
      obf_n  <= 1'b1;
      intr   <= 1'b0;
      inte   <= 1'b0;
    end else begin
      if (bit_wr) begin
        if (hs_bit) begin
          if (bsel == 3'd2) inte <= wdata[0];
        end else begin
          c_lat[bsel] <= wdata[0];
        end
      end
      if (wr_en && addr == 2'd0) a_lat <= wdata;
      if (wr_en && addr == 2'd1) b_lat <= wdata;
      if (wr_en && addr == 2'd2) c_lat <= wdata;
      if (hs_in) begin
        if (rd_en && addr == 2'd1) begin
          ibf  <= 1'b0;
          intr <= 1'b0;
        end
        if (hs_edge) begin
          b_cap <= b_q;
          ibf   <= 1'b1;
          intr  <= inte;
        end
      end
      if (hs_out) begin
        if (wr_en && addr == 2'd1) begin
          obf_n <= 1'b0;
          intr  <= 1'b0;
        end
        if (hs_edge) begin
          obf_n <= 1'b1;
          intr  <= inte;
        end
      end
    end
  end

  assign c_drv  = b_strb ? {c_lat[7:3], 1'b0, (b_in ? ibf : obf_n), intr} : c_lat;
  assign pa_out = a_lat;
  assign pb_out = b_lat;
  assign pc_out = c_drv;
  assign pa_oe  = {8{!a_in}};
  assign pb_oe  = {8{!b_in}};
  assign pc_oe  = {{4{!cu_in}}, !cl_in, (b_strb ? 3'b011 : {3{!cl_in}})};

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      case (addr)
        2'd0:    rdata = a_in ? a_q : a_lat;
        2'd1:    rdata = hs_in ? b_cap : (b_in ? b_q : b_lat);
        2'd2:    rdata = (c_drv & pc_oe) | (c_q & ~pc_oe);
        default: rdata = 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/pport_ctrl_chk.sv
module pport_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe
);
  logic ctl_wr;
  assign ctl_wr = !cs_n && !wr_n && addr == 2'd3;

  assert_mode_a_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[7] && wdata[6:5] == 2'b00) |=> pa_oe == {8{!$past(wdata[4])}});

  assert_mode_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out[7:3] == 5'h00));

  assert_write_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 2'd0) |=> pa_out == $past(wdata));

  assert_bitcmd_keeps_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  assert_upper_half_uniform_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF));

  assert_intr_implies_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_oe == 8'h00 && pc_oe[2:0] == 3'b011 && pc_out[0]) |-> pc_out[1]);
endmodule

bind pport_ctrl pport_ctrl_chk u_chk (.*);

// File: tb/pport_ctrl_bench.sv
module pport_ctrl_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int checks = 0, fails = 0;
  logic [7:0] r;

  always #(CLK_P/2) clk = ~clk;

  pport_ctrl u_pport_ctrl (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; wdata = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic strobe();
    @(negedge clk); pc_in[2] = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic unstrobe();
    @(negedge clk); pc_in[2] = 1;
    @(negedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] exp_coe(input logic [4:0] m);
    return {{4{~m[3]}}, ~m[0], (m[2] ? 3'b011 : {3{~m[0]}})};
  endfunction

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pc_in = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pc_out", pc_out, 8'h00);
    rd(2'd2, r); chk("R1 read C pins", r, 8'h5A);
    rd(2'd3, r); chk("R2 control read", r, 8'hFF);
    #1 chk("R2 idle rdata", rdata, 8'h00);

    // R6: pin change only visible after a rising edge
    pa_in = 8'h33;
    @(negedge clk); pa_in = 8'hC4; cs_n = 0; rd_n = 0; addr = 2'd0;
    #1 chk("R6 before edge", rdata, 8'h33);
    @(negedge clk); #1 chk("R6 after edge", rdata, 8'hC4);
    cs_n = 1; rd_n = 1;

    // Sweep all 32 direction/mode combinations
    for (int k = 0; k < 32; k++) begin
      logic [7:0] av, bv, cv, ap, bp, cp, coe;
      av = 8'(k * 37 + 1); bv = ~av; cv = av ^ 8'h5A;
      ap = av ^ 8'hF0; bp = bv ^ 8'h0F; cp = ~cv;
      wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
      wr(2'd3, 8'h80 | 8'(k));
      chk("R4 pa cleared", pa_out, 8'h00);
      chk("R4 pb cleared", pb_out, 8'h00);
      chk("R4 pc upper cleared", pc_out & 8'hF8, 8'h00);
      coe = exp_coe(5'(k));
      chk("R3 pa_oe", pa_oe, k[4] ? 8'h00 : 8'hFF);
      chk("R3 pb_oe", pb_oe, k[1] ? 8'h00 : 8'hFF);
      chk("R8 pc_oe", pc_oe, coe);
      if (!k[2]) begin
        pa_in = ap; pb_in = bp; pc_in = cp;
        wr(2'd0, av); wr(2'd1, bv); wr(2'd2, cv);
        chk("R5 pa_out", pa_out, av);
        chk("R5 pb_out", pb_out, bv);
        chk("R5 pc_out", pc_out, cv);
        rd(2'd0, r); chk("R5 R6 read A", r, k[4] ? ap : av);
        rd(2'd1, r); chk("R5 R6 read B", r, k[1] ? bp : bv);
        rd(2'd2, r); chk("R8 read C", r, (cv & coe) | (cp & ~coe));
      end
    end

    // R13: port A mode field forces input
    for (int m = 1; m < 4; m++) begin
      wr(2'd3, 8'h80 | 8'(m << 5));
      chk("R13 pa_oe", pa_oe, 8'h00);
    end
    wr(2'd3, 8'h80);
    chk("R13 basic pa_oe", pa_oe, 8'hFF);

    // R7: set/reset sweep, all outputs
    for (int b = 0; b < 8; b++) begin
      wr(2'd3, 8'(b << 1) | 8'h01);
      chk("R7 set bit", pc_out, 8'((1 << (b + 1)) - 1));
      chk("R7 dir kept", pc_oe, 8'hFF);
    end
    for (int b = 0; b < 8; b++) begin
      wr(2'd3, 8'(b << 1));
      chk("R7 clear bit", pc_out, 8'hFF << (b + 1));
    end

    // R9 R10 R11: strobed input
    pc_in = 8'h04;
    wr(2'd3, 8'h86);
    chk("R9 pc_oe", pc_oe, 8'hFB);
    chk("R9 pb_oe", pb_oe, 8'h00);
    pb_in = 8'h3C;
    strobe();
    chk("R9 ibf set", pc_out & 8'h03, 8'h02);
    rd(2'd1, r); chk("R9 captured B", r, 8'h3C);
    chk("R10 ibf cleared", pc_out & 8'h03, 8'h00);
    unstrobe();
    wr(2'd3, 8'h03);
    wr(2'd3, 8'h01);
    chk("R11 lines 0/1 ignored", pc_out & 8'h03, 8'h00);
    wr(2'd3, 8'h05);
    pb_in = 8'hA5;
    strobe();
    chk("R11 intr with enable", pc_out & 8'h03, 8'h03);
    pb_in = 8'h11;
    @(negedge clk);
    rd(2'd1, r); chk("R9 capture held", r, 8'hA5);
    chk("R10 both cleared", pc_out & 8'h03, 8'h00);
    unstrobe();

    // R12: strobed output
    wr(2'd3, 8'h84);
    chk("R12 obf idle high", pc_out & 8'h03, 8'h02);
    chk("R12 pb_oe", pb_oe, 8'hFF);
    wr(2'd3, 8'h05);
    wr(2'd1, 8'h77);
    chk("R12 pb_out", pb_out, 8'h77);
    chk("R12 obf low", pc_out & 8'h03, 8'h00);
    strobe();
    chk("R12 ack sets obf intr", pc_out & 8'h03, 8'h03);
    unstrobe();
    wr(2'd1, 8'h12);
    chk("R12 write clears intr", pc_out & 8'h03, 8'h00);
    wr(2'd3, 8'h84);
    chk("R11 enable cleared", pc_out & 8'h03, 8'h02);
    strobe();
    chk("R11 ack without enable", pc_out & 8'h03, 8'h02);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule